// File: doc/BRIEF.md
# General-Purpose Event Status Controller

The block keeps a 64-bit power-management event status word and a matching 64-bit enable word. Hardware sources set status bits. There are up to sixteen GPIO inputs, each qualified by an "is input" flag and a per-pin polarity invert, plus two USB-controller wake requests. Software reads the status word through a small 32-bit register port and clears bits by writing ones. An asserted source outranks a clear in the same cycle, so a still-active condition is never lost.

Each status bit that is also enabled is pending. While the system sleeps (S1–S5), any pending bit raises `wake`. In S0, pending USB events go to SCI when the SCI-enable input is high and to SMI when it is low. Pending GPIO events follow a per-pin two-bit route field. `wake`, `sci` and `smi` are levels. They are decoded from registered state and the present mode inputs, and they fall once software clears the bits behind them.

There are two reset sources. The resume-well reset `rst_n` is asynchronous and active low, and it clears everything. It is expected to be released synchronously upstream. The platform-reset pulse `plat_rst` is synchronous and clears only the GPIO status field.

Top module: `gpe_status_ctrl`

## Requirements
- R1: After `rst_n` is released, all four register words read zero and `wake`, `sci` and `smi` are low.
- R2: The word select `addr` picks the word: 0 is status[31:0], 1 is status[63:32], 2 is enable[31:0] and 3 is enable[63:32]. GPIO i sits at bit 16+i, USB source A at bit 14 and USB source B at bit 32 (word 1, bit 0). Every other bit reads zero, and writes to it have no effect.
- R3: GPIO status bit i is set on the clock edge where `gpio_is_input[i]` is high and `gpio_in[i] ^ gpio_inv[i]` is 1. It stays set after the condition goes away. A pin not marked as input never sets its bit.
- R4: `usb_a_wake` sets bit 14 and `usb_b_wake` sets bit 32 on the next clock edge. Both bits are sticky.
- R5: A write to word 0 or word 1 clears each implemented status bit whose data bit is 1. Data bits that are 0 leave status unchanged.
- R6: If a source is asserted in the same cycle as a write-one clear of its bit, the bit stays set.
- R7: A cycle with `plat_rst` high clears bits 31:16 on the next edge, even while the GPIO sources are active. Bits 14 and 32 keep their values.
- R8: Writes to words 2 and 3 load the enable bits at the implemented positions. Enable bits change only on such writes.
- R9: `wake` is high exactly when `in_s0` is low and some status bit is set together with its enable bit. `sci` and `smi` are low whenever `in_s0` is low.
- R10: In S0, a pending USB bit drives `sci` when `sci_en` is 1 and `smi` when `sci_en` is 0.
- R11: In S0, the route field `gpio_route[2i+1:2i]` steers pending GPIO i. The value 00 or 11 does nothing and 01 drives `smi`. The value 10 drives `sci` when `sci_en` is 1 and `smi` when `sci_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Resume-well reset, asynchronous, active low |
| plat_rst | input | 1 | Platform-reset pulse, clears the GPIO status field |
| addr | input | 2 | Register word select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected word |
| gpio_in | input | NUM_GPIO | GPIO signal levels |
| gpio_is_input | input | NUM_GPIO | Pin configured as input |
| gpio_inv | input | NUM_GPIO | Per-pin polarity invert |
| gpio_route | input | 2*NUM_GPIO | Per-pin route field |
| usb_a_wake | input | 1 | Wake request from USB source A |
| usb_b_wake | input | 1 | Wake request from USB source B |
| in_s0 | input | 1 | 1 when the system is in S0, 0 for S1–S5 |
| sci_en | input | 1 | SCI-enable flag |
| wake | output | 1 | Wake event level |
| sci | output | 1 | SCI level |
| smi | output | 1 | SMI level |

## Verification
The bench builds the block with the default NUM_GPIO of 16. This fills the GPIO field up to bit 31, so the top pin, the boundary between bit 15 and bit 16 where the platform reset takes effect, and the jump from word 0 to the USB bit in word 1 are all exercised. With all sixteen route fields live, the random phase can mix pins routed to SMI, SCI and nowhere in the same cycle. It can also mix both USB sources, power-state changes and SCI-enable changes against a running model.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned STS_W     = 64;
  localparam int unsigned GPIO_BASE = 16;
  localparam int unsigned GPIO_MAX  = 16;
  localparam int unsigned USB_A_BIT = 14;
  localparam int unsigned USB_B_BIT = 32;

  localparam logic [1:0] WORD_STS_LO = 2'd0;
  localparam logic [1:0] WORD_STS_HI = 2'd1;
  localparam logic [1:0] WORD_EN_LO  = 2'd2;
  localparam logic [1:0] WORD_EN_HI  = 2'd3;

endpackage

// File: rtl/gpe_sts_cell.sv
module gpe_sts_cell #(
  parameter bit PLAT_DOMAIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic prst_i,
  output logic q_o
);

  logic q_q;
  logic q_d;
  logic prst_eff;

  assign prst_eff = PLAT_DOMAIN & prst_i;

  // Priority, highest first: platform clear, hardware set, software clear.
  always_comb begin
    q_d = q_q;
    if (clr_i)    q_d = 1'b0;
    if (set_i)    q_d = 1'b1;
    if (prst_eff) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !prst_eff) |=> q_o);

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i && !prst_eff) |=> !q_o);

  generate
    if (PLAT_DOMAIN) begin : g_plat
      // R7
      plat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prst_i |=> !q_o);
    end else begin : g_keep
      // R7
      plat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_i && q_o && !clr_i) |=> q_o);
    end
  endgenerate

endmodule

// File: rtl/gpe_en_reg.sv
module gpe_en_reg #(
  parameter logic [63:0] IMPL_MASK = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] en_o
);

  logic [63:0] en_q;
  logic [63:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_lo) en_d[31:0]  = wdata & IMPL_MASK[31:0];
    if (wr_hi) en_d[63:32] = wdata & IMPL_MASK[63:32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             en_q <= '0;
    else if (wr_lo || wr_hi) en_q <= en_d;
  end

  assign en_o = en_q;

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_lo && !wr_hi) |=> $stable(en_o));

endmodule

// File: rtl/gpe_router.sv
module gpe_router
  import gpe_pkg::*;
#(
  parameter int unsigned NUM_GPIO = 16
) (
  input  logic [NUM_GPIO-1:0]   gpio_pend,
  input  logic [2*NUM_GPIO-1:0] gpio_route,
  input  logic [1:0]            usb_pend,
  input  logic                  in_s0,
  input  logic                  sci_en,
  output logic                  wake,
  output logic                  sci,
  output logic                  smi
);

  logic gpio_sci_req;
  logic gpio_smi_req;
  logic legacy_req;
  route_e rt;

  always_comb begin
    gpio_sci_req = 1'b0;
    gpio_smi_req = 1'b0;
    rt           = ROUTE_NONE;
    for (int i = 0; i < int'(NUM_GPIO); i++) begin
      rt = route_e'(gpio_route[2*i +: 2]);
      if (gpio_pend[i] && rt == ROUTE_SCI) gpio_sci_req = 1'b1;
      if (gpio_pend[i] && rt == ROUTE_SMI) gpio_smi_req = 1'b1;
    end
  end

  assign legacy_req = (|usb_pend) | gpio_sci_req;
  assign wake = !in_s0 && ((|gpio_pend) || (|usb_pend));
  assign sci  = in_s0 && sci_en && legacy_req;
  assign smi  = in_s0 && ((!sci_en && legacy_req) || gpio_smi_req);

endmodule

// File: rtl/gpe_status_ctrl.sv
module gpe_status_ctrl
  import gpe_pkg::*;
#(
  parameter int unsigned NUM_GPIO = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  plat_rst,
  input  logic [1:0]            addr,
  input  logic                  wr_en,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_GPIO-1:0]   gpio_in,
  input  logic [NUM_GPIO-1:0]   gpio_is_input,
  input  logic [NUM_GPIO-1:0]   gpio_inv,
  input  logic [2*NUM_GPIO-1:0] gpio_route,
  input  logic                  usb_a_wake,
  input  logic                  usb_b_wake,
  input  logic                  in_s0,
  input  logic                  sci_en,
  output logic                  wake,
  output logic                  sci,
  output logic                  smi
);

  localparam logic [63:0] GPIO_MASK =
    ((64'd1 << NUM_GPIO) - 64'd1) << GPIO_BASE;
  localparam logic [63:0] IMPL_MASK =
    GPIO_MASK | (64'd1 << USB_A_BIT) | (64'd1 << USB_B_BIT);

  logic                wr_sts_lo;
  logic                wr_sts_hi;
  logic                wr_en_lo;
  logic                wr_en_hi;
  logic [NUM_GPIO-1:0] gpio_hit;
  logic [NUM_GPIO-1:0] gpio_clr;
  logic [NUM_GPIO-1:0] gpio_q;
  logic                usb_a_q;
  logic                usb_b_q;
  logic [63:0]         sts_q;
  logic [63:0]         en_q;
  logic [NUM_GPIO-1:0] gpio_pend;
  logic [1:0]          usb_pend;

  assign wr_sts_lo = wr_en && (addr == WORD_STS_LO);
  assign wr_sts_hi = wr_en && (addr == WORD_STS_HI);
  assign wr_en_lo  = wr_en && (addr == WORD_EN_LO);
  assign wr_en_hi  = wr_en && (addr == WORD_EN_HI);

  assign gpio_hit = gpio_is_input & (gpio_in ^ gpio_inv);
  assign gpio_clr = wr_sts_lo ? wdata[GPIO_BASE +: NUM_GPIO] : '0;

  generate
    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
      gpe_sts_cell #(.PLAT_DOMAIN(1'b1)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (gpio_hit[g]),
        .clr_i  (gpio_clr[g]),
        .prst_i (plat_rst),
        .q_o    (gpio_q[g])
      );
    end
  endgenerate

  gpe_sts_cell #(.PLAT_DOMAIN(1'b0)) u_usb_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (usb_a_wake),
    .clr_i  (wr_sts_lo && wdata[USB_A_BIT]),
    .prst_i (plat_rst),
    .q_o    (usb_a_q)
  );

  gpe_sts_cell #(.PLAT_DOMAIN(1'b0)) u_usb_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (usb_b_wake),
    .clr_i  (wr_sts_hi && wdata[USB_B_BIT-32]),
    .prst_i (plat_rst),
    .q_o    (usb_b_q)
  );

  always_comb begin
    sts_q = '0;
    sts_q[GPIO_BASE +: NUM_GPIO] = gpio_q;
    sts_q[USB_A_BIT]             = usb_a_q;
    sts_q[USB_B_BIT]             = usb_b_q;
  end

  gpe_en_reg #(.IMPL_MASK(IMPL_MASK)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_en_lo),
    .wr_hi (wr_en_hi),
    .wdata (wdata),
    .en_o  (en_q)
  );

  assign gpio_pend = gpio_q & en_q[GPIO_BASE +: NUM_GPIO];
  assign usb_pend  = {usb_b_q & en_q[USB_B_BIT], usb_a_q & en_q[USB_A_BIT]};

  gpe_router #(.NUM_GPIO(NUM_GPIO)) u_router (
    .gpio_pend  (gpio_pend),
    .gpio_route (gpio_route),
    .usb_pend   (usb_pend),
    .in_s0      (in_s0),
    .sci_en     (sci_en),
    .wake       (wake),
    .sci        (sci),
    .smi        (smi)
  );

  always_comb begin
    case (addr)
      WORD_STS_LO: rdata = sts_q[31:0];
      WORD_STS_HI: rdata = sts_q[63:32];
      WORD_EN_LO:  rdata = en_q[31:0];
      default:     rdata = en_q[63:32];
    endcase
  end

  // R9
  wake_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_s0 && ((sts_q & en_q) != 64'd0)) |-> wake);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_s0 |-> (!sci && !smi));

  // R2
  hi_word_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == WORD_STS_HI) |-> (rdata[31:1] == 31'd0));

endmodule

// File: tb/gpe_status_ctrl_bench.sv
`timescale 1ns/100ps
module gpe_status_ctrl_bench;

  localparam int NG = 16;
  localparam logic [63:0] MASK = 64'h0000_0001_FFFF_4000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            plat_rst;
  logic [1:0]      addr;
  logic            wr_en;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NG-1:0]   gpio_in, gpio_is_input, gpio_inv;
  logic [2*NG-1:0] gpio_route;
  logic            usb_a_wake, usb_b_wake, in_s0, sci_en;
  logic            wake, sci, smi;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] exp_sts, exp_en;

  always #4 clk = ~clk;

  gpe_status_ctrl #(.NUM_GPIO(NG)) u_gpe_status_ctrl (
    .clk(clk), .rst_n(rst_n), .plat_rst(plat_rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in), .gpio_is_input(gpio_is_input),
    .gpio_inv(gpio_inv), .gpio_route(gpio_route), .usb_a_wake(usb_a_wake),
    .usb_b_wake(usb_b_wake), .in_s0(in_s0), .sci_en(sci_en),
    .wake(wake), .sci(sci), .smi(smi)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] f_sts(input logic [63:0] cur);
    logic [63:0] clr = '0;
    logic [63:0] set = '0;
    logic [63:0] n;
    if (wr_en && addr == 2'd0) clr[31:0]  = wdata;
    if (wr_en && addr == 2'd1) clr[63:32] = wdata;
    for (int i = 0; i < NG; i++)
      set[16+i] = gpio_is_input[i] & (gpio_in[i] ^ gpio_inv[i]);
    set[14] = usb_a_wake;
    set[32] = usb_b_wake;
    n = (cur & ~(clr & MASK)) | set;
    if (plat_rst) n[31:16] = '0;
    return n & MASK;
  endfunction

  function automatic logic [63:0] f_en(input logic [63:0] cur);
    logic [63:0] n = cur;
    if (wr_en && addr == 2'd2) n[31:0]  = wdata;
    if (wr_en && addr == 2'd3) n[63:32] = wdata;
    return n & MASK;
  endfunction

  function automatic logic [2:0] f_out();
    logic [63:0] p = exp_sts & exp_en;
    logic legacy, gsmi;
    legacy = p[14] | p[32];
    gsmi   = 1'b0;
    for (int i = 0; i < NG; i++) begin
      if (p[16+i] && gpio_route[2*i +: 2] == 2'b10) legacy = 1'b1;
      if (p[16+i] && gpio_route[2*i +: 2] == 2'b01) gsmi   = 1'b1;
    end
    return {!in_s0 && (p != 0), in_s0 && sci_en && legacy,
            in_s0 && ((!sci_en && legacy) || gsmi)};
  endfunction

  function automatic logic [31:0] f_word(input logic [1:0] a);
    case (a)
      2'd0: return exp_sts[31:0];
      2'd1: return exp_sts[63:32];
      2'd2: return exp_en[31:0];
      default: return exp_en[63:32];
    endcase
  endfunction

  task automatic tick();
    logic [63:0] ns, ne;
    ns = f_sts(exp_sts);
    ne = f_en(exp_en);
    @(posedge clk);
    #1;
    exp_sts = ns;
    exp_en  = ne;
  endtask

  task automatic idle();
    plat_rst = 0; wr_en = 0; wdata = '0; addr = '0;
    gpio_in = '0; gpio_is_input = '0; gpio_inv = '0;
    usb_a_wake = 0; usb_b_wake = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    wr_en = 0; addr = a; #0.2; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    idle(); in_s0 = 1; sci_en = 1; gpio_route = '0;
    rst_n = 0; exp_sts = '0; exp_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1", "word after reset", 64'(d), 64'd0);
    end
    chk("R1", "outputs after reset", {61'd0, wake, sci, smi}, 64'd0);

    // R3 inverted top pin sets bit 31; non-input pin does nothing
    gpio_is_input[15] = 1; gpio_inv[15] = 1; gpio_in[3] = 1;
    tick(); idle();
    rd(0, d); chk("R3", "gpio15 inverted / pin3 not input", 64'(d), 64'h8000_0000);
    tick(); rd(0, d); chk("R3", "gpio bit sticky", 64'(d), 64'h8000_0000);

    // R4 USB sources
    usb_a_wake = 1; usb_b_wake = 1; tick(); idle();
    rd(0, d); chk("R4", "usb A bit 14", 64'(d), 64'h8000_4000);
    rd(1, d); chk("R4", "usb B bit 32", 64'(d), 64'h1);

    // R5 write one clears, zero leaves
    wr(0, 32'h8000_0000); rd(0, d); chk("R5", "w1c bit31", 64'(d), 64'h4000);
    wr(0, 32'h0);         rd(0, d); chk("R5", "write zero", 64'(d), 64'h4000);

    // R6 set beats clear
    usb_a_wake = 1; wr(0, 32'h4000); idle();
    rd(0, d); chk("R6", "set wins over clear", 64'(d), 64'h4000);
    wr(0, 32'h4000); rd(0, d); chk("R6", "clear after source drops", 64'(d), 64'h0);

    // R7 platform reset
    usb_a_wake = 1; gpio_is_input[0] = 1; gpio_in[0] = 1; tick();
    plat_rst = 1; tick(); idle();
    rd(0, d); chk("R7", "gpio field cleared, bit14 kept", 64'(d), 64'h4000);
    rd(1, d); chk("R7", "bit32 kept", 64'(d), 64'h1);

    // R2 reserved bits and high word
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2", "high word after w1c", 64'(d), 64'h0);
    wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2", "low word cleared", 64'(d), 64'h0);

    // R8 enable register
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R8", "enable low mask", 64'(d), 64'hFFFF_4000);
    wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R8", "enable high mask", 64'(d), 64'h1);
    tick(); rd(2, d); chk("R8", "enable holds", 64'(d), 64'hFFFF_4000);

    // R9 wake in sleep
    in_s0 = 0; usb_b_wake = 1; tick(); idle(); #0.2;
    chk("R9", "sleep wake", {61'd0, wake, sci, smi}, 64'b100);
    wr(1, 32'h1); #0.2;
    chk("R9", "wake drops after clear", {61'd0, wake, sci, smi}, 64'b000);

    // R10 USB in S0
    in_s0 = 1; sci_en = 1; usb_a_wake = 1; tick(); idle(); #0.2;
    chk("R10", "usb sci", {61'd0, wake, sci, smi}, 64'b010);
    sci_en = 0; #0.2;
    chk("R10", "usb smi", {61'd0, wake, sci, smi}, 64'b001);
    wr(0, 32'h4000); #0.2;
    chk("R10", "drop after clear", {61'd0, wake, sci, smi}, 64'b000);

    // R11 GPIO routing, pin 2
    sci_en = 1; gpio_is_input[2] = 1; gpio_in[2] = 1; tick(); idle();
    gpio_route[5:4] = 2'b00; #0.2;
    chk("R11", "route 00", {61'd0, wake, sci, smi}, 64'b000);
    gpio_route[5:4] = 2'b01; #0.2;
    chk("R11", "route 01", {61'd0, wake, sci, smi}, 64'b001);
    gpio_route[5:4] = 2'b10; #0.2;
    chk("R11", "route 10 sci_en", {61'd0, wake, sci, smi}, 64'b010);
    sci_en = 0; #0.2;
    chk("R11", "route 10 no sci_en", {61'd0, wake, sci, smi}, 64'b001);
    gpio_route[5:4] = 2'b11; #0.2;
    chk("R11", "route 11", {61'd0, wake, sci, smi}, 64'b000);
    in_s0 = 0; #0.2;
    chk("R9", "gpio wake in sleep", {61'd0, wake, sci, smi}, 64'b100);
    wr(0, 32'h0004_0000); in_s0 = 1; #0.2;

    // Random phase against the model
    for (int k = 0; k < 3000; k++) begin
      gpio_in       = NG'($urandom);
      gpio_is_input = NG'($urandom & $urandom & $urandom);
      gpio_inv      = NG'($urandom);
      gpio_route    = 32'($urandom);
      usb_a_wake    = ($urandom % 16) == 0;
      usb_b_wake    = ($urandom % 16) == 0;
      plat_rst      = ($urandom % 32) == 0;
      in_s0         = ($urandom % 3) != 0;
      sci_en        = $urandom % 2;
      addr          = 2'($urandom);
      wr_en         = ($urandom % 3) == 0;
      wdata         = $urandom;
      tick();
      chk(addr < 2 ? "R5" : "R8", "random word", 64'(rdata), 64'(f_word(addr)));
      chk(in_s0 ? "R11" : "R9", "random outputs",
          {61'd0, wake, sci, smi}, {61'd0, f_out()});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule